// File: doc/BRIEF.md
# Double-Buffered Block-Mode Receive Manager

This block manages the two byte buffers behind a serial message receiver. Bytes arrive already decoded, each with a strobe. An end-of-data strobe closes a message, and it comes with the pass or fail result of the message check. A separate strobe reports receive errors such as an invalid bit. In normal mode each message lands in one buffer. The buffer is handed to the CPU once the message ends with a good check.

In block mode a message longer than one buffer is split across the two buffers in alternation. The buffer being filled is handed over as soon as it is full, and the next bytes go into the other buffer. The CPU arms block mode with a set strobe. Only the hardware clears it, and it pulses a clear indication when it does so. The hardware clears block mode at end of data, on a receive error, or when a byte arrives while both buffers still wait for the CPU.

The CPU always sees one buffer: its byte count, its bytes by index, a success flag and a level interrupt. A release strobe returns that buffer and moves the view to the other one.

Top module: `blkrx_mgr`

## Requirements
- R1: After reset the count, success flag, interrupt, block-mode flag, clear pulse and overflow flag are all 0.
- R2: In normal mode, an end-of-data strobe with a good check makes the filling buffer visible. The count equals the number of bytes received, and byte k of the message is read at index k.
- R3: The success flag and count describe only a completed buffer presented to the CPU. While no completed buffer is presented, the count reads 0.
- R4: The interrupt is high exactly while the success flag is set and the interrupt enable input is 1.
- R5: A receive error strobe, or end-of-data with a failed check, discards the bytes of the partly filled buffer. The next message starts from an empty buffer. Completed buffers are kept.
- R6: The block-mode set strobe raises the block-mode flag on the next cycle. While it is set, the byte that fills a buffer (8 bytes by default) completes that buffer at once, and later bytes go to the other buffer.
- R7: In block mode the count shows only the bytes of the presented buffer, never a total over the message.
- R8: End-of-data clears block mode on the next cycle. With a good check, the partial last buffer is completed. With a failed check, it is discarded. Every hardware clear of an active block mode gives a one-cycle clear pulse, in the same cycle the flag drops.
- R9: A receive error strobe clears block mode on the next cycle.
- R10: A byte that arrives while the filling target still holds a completed, unreleased buffer is discarded. It sets the overflow flag and ends block mode. The flag stays set until a release is accepted.
- R11: A release strobe frees the presented completed buffer and presents the other buffer. A release while no completed buffer is presented is ignored.
- R12: In normal mode, bytes beyond the buffer capacity are discarded. The message still completes with a count equal to the capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| byte_vld | input | 1 | Received byte strobe |
| byte_data | input | DATA_W | Received byte |
| eod | input | 1 | End-of-data strobe |
| crc_ok | input | 1 | Message check result, valid with eod |
| rx_err | input | 1 | Receive error strobe |
| blk_set | input | 1 | CPU request to arm block mode |
| int_en | input | 1 | Interrupt enable |
| buf_release | input | 1 | CPU releases the presented buffer |
| rd_idx | input | log2(BUF_BYTES) | Byte index into the presented buffer |
| blk_mode | output | 1 | Block mode active |
| blk_clr | output | 1 | One-cycle pulse when hardware clears block mode |
| rx_ok | output | 1 | Presented buffer holds a completed message part |
| irq | output | 1 | Interrupt request level |
| ovf | output | 1 | A byte was lost for lack of a free buffer |
| cur_count | output | log2(BUF_BYTES+1) | Byte count of the presented buffer |
| rd_data | output | DATA_W | Byte at rd_idx of the presented buffer |

## Verification
The hardest state to reach from the ports is the double-full overflow in block mode. Both buffers must be completed by a single message while the CPU releases neither, and only then does one more byte arrive. The stimulus arms block mode and streams twice the buffer capacity without a release before sending the extra byte. After the overflow, it releases one buffer and reads the last index of the second buffer, which shows the discarded byte overwrote nothing. A second path sends two complete normal messages without a release and then a stray byte, which overflows without touching block mode.

// File: rtl/blkrx_pkg.sv
package blkrx_pkg;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_BYTE = 2'd1,
    EV_EOD  = 2'd2,
    EV_ERR  = 2'd3
  } rx_ev_e;

  typedef struct packed {
    logic wr_en;
    logic seal;
    logic drop;
    logic free;
  } slot_cmd_t;

  // True when a buffer holding cnt bytes can take one more.
  function automatic logic has_room(input int unsigned cnt, input int unsigned cap);
    return cnt < cap;
  endfunction

  // True when the byte now written is the one that fills the buffer.
  function automatic logic fills_up(input int unsigned cnt, input int unsigned cap);
    return (cnt + 1) == cap;
  endfunction

  // Event priority: an error outranks end-of-data, which outranks a byte.
  function automatic rx_ev_e pick_event(input logic err, input logic eod, input logic bv);
    if (err)      return EV_ERR;
    else if (eod) return EV_EOD;
    else if (bv)  return EV_BYTE;
    return EV_NONE;
  endfunction

endpackage

// File: rtl/blkrx_slot.sv
module blkrx_slot
  import blkrx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_cmd_t         cmd,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CNT_W-1:0]  cnt,
  output logic              ready,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (cmd.wr_en) mem[cnt[IDX_W-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (cmd.free) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (cmd.drop) begin
      cnt   <= '0;
    end else begin
      if (cmd.wr_en) cnt   <= cnt + 1'b1;
      if (cmd.seal)  ready <= 1'b1;
    end
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/blkrx_ctrl.sv
module blkrx_ctrl
  import blkrx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  byte_vld,
  input  logic                  eod,
  input  logic                  crc_ok,
  input  logic                  rx_err,
  input  logic                  blk_set,
  input  logic                  buf_release,
  input  logic [1:0][CNT_W-1:0] slot_cnt,
  input  logic [1:0]            slot_rdy,
  output slot_cmd_t [1:0]       cmd,
  output logic                  wr_sel,
  output logic                  rd_sel,
  output logic                  blk_mode,
  output logic                  blk_clr,
  output logic                  ovf,
  output logic [CNT_W-1:0]      wr_fill,
  output logic                  ev_accept,
  output logic                  ev_overflow,
  output logic                  ev_release_ok
);

  rx_ev_e ev;
  logic   wr_rdy;
  logic   ev_seal;
  logic   ev_drop;
  logic   mode_kill;

  assign ev      = pick_event(rx_err, eod, byte_vld);
  assign wr_fill = slot_cnt[wr_sel];
  assign wr_rdy  = slot_rdy[wr_sel];

  assign ev_overflow   = (ev == EV_BYTE) && wr_rdy;
  assign ev_accept     = (ev == EV_BYTE) && !wr_rdy && has_room(32'(wr_fill), DEPTH);
  assign ev_release_ok = buf_release && slot_rdy[rd_sel];

  // A buffer completes on the filling byte in block mode, or at a good end-of-data.
  assign ev_seal = (ev_accept && blk_mode && fills_up(32'(wr_fill), DEPTH)) ||
                   ((ev == EV_EOD) && crc_ok && !wr_rdy && (wr_fill != '0));
  assign ev_drop = ((ev == EV_ERR) || ((ev == EV_EOD) && !crc_ok)) && !wr_rdy;

  assign mode_kill = (ev == EV_ERR) || (ev == EV_EOD) || ev_overflow;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      cmd[i].wr_en = ev_accept     && (wr_sel == 1'(i));
      cmd[i].seal  = ev_seal       && (wr_sel == 1'(i));
      cmd[i].drop  = ev_drop       && (wr_sel == 1'(i));
      cmd[i].free  = ev_release_ok && (rd_sel == 1'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sel   <= 1'b0;
      rd_sel   <= 1'b0;
      blk_mode <= 1'b0;
      blk_clr  <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      wr_sel   <= wr_sel ^ ev_seal;
      rd_sel   <= rd_sel ^ ev_release_ok;
      blk_mode <= mode_kill ? 1'b0 : (blk_mode | blk_set);
      blk_clr  <= mode_kill && blk_mode;
      if (ev_overflow)        ovf <= 1'b1;
      else if (ev_release_ok) ovf <= 1'b0;
    end
  end

endmodule

// File: rtl/blkrx_mgr.sv
module blkrx_mgr
  import blkrx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BUF_BYTES = 8,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1),
  localparam int IDX_W    = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              eod,
  input  logic              crc_ok,
  input  logic              rx_err,
  input  logic              blk_set,
  input  logic              int_en,
  input  logic              buf_release,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              blk_mode,
  output logic              blk_clr,
  output logic              rx_ok,
  output logic              irq,
  output logic              ovf,
  output logic [CNT_W-1:0]  cur_count,
  output logic [DATA_W-1:0] rd_data
);

  localparam int NBUF = 2;

  slot_cmd_t [NBUF-1:0]             cmd;
  logic      [NBUF-1:0][CNT_W-1:0]  slot_cnt;
  logic      [NBUF-1:0]             slot_rdy;
  logic      [NBUF-1:0][DATA_W-1:0] slot_data;
  logic                             wr_sel;
  logic                             rd_sel;
  logic      [CNT_W-1:0]            wr_fill;
  logic                             ev_accept;
  logic                             ev_overflow;
  logic                             ev_release_ok;

  blkrx_ctrl #(.DEPTH(BUF_BYTES)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .byte_vld      (byte_vld),
    .eod           (eod),
    .crc_ok        (crc_ok),
    .rx_err        (rx_err),
    .blk_set       (blk_set),
    .buf_release   (buf_release),
    .slot_cnt      (slot_cnt),
    .slot_rdy      (slot_rdy),
    .cmd           (cmd),
    .wr_sel        (wr_sel),
    .rd_sel        (rd_sel),
    .blk_mode      (blk_mode),
    .blk_clr       (blk_clr),
    .ovf           (ovf),
    .wr_fill       (wr_fill),
    .ev_accept     (ev_accept),
    .ev_overflow   (ev_overflow),
    .ev_release_ok (ev_release_ok)
  );

  for (genvar g = 0; g < NBUF; g++) begin : g_slot
    blkrx_slot #(.DATA_W(DATA_W), .DEPTH(BUF_BYTES)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd[g]),
      .wr_data (byte_data),
      .rd_idx  (rd_idx),
      .cnt     (slot_cnt[g]),
      .ready   (slot_rdy[g]),
      .rd_data (slot_data[g])
    );
  end

  assign rx_ok     = slot_rdy[rd_sel];
  assign cur_count = rx_ok ? slot_cnt[rd_sel] : '0;
  assign rd_data   = slot_data[rd_sel];
  assign irq       = rx_ok & int_en;

endmodule

// File: rtl/blkrx_chk.sv
module blkrx_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eod,
  input logic             rx_err,
  input logic             blk_mode,
  input logic             blk_clr,
  input logic             ovf,
  input logic             rx_ok,
  input logic [CNT_W-1:0] cur_count,
  input logic             rd_sel,
  input logic             wr_sel,
  input logic [CNT_W-1:0] wr_fill,
  input logic             ev_accept,
  input logic             ev_overflow,
  input logic             ev_release_ok
);

  a_r9_err_ends_block: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |=> !blk_mode);

  a_r8_eod_ends_block: assert property (@(posedge clk) disable iff (!rst_n)
    eod |=> !blk_mode);

  a_r8_clr_pulse_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    blk_clr |-> (!blk_mode && $past(blk_mode)));

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ev_release_ok) |=> ovf);

  a_r10_ovf_exits_block: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow |=> (ovf && !blk_mode));

  a_r11_release_moves_view: assert property (@(posedge clk) disable iff (!rst_n)
    ev_release_ok |=> (rd_sel != $past(rd_sel)));

  a_r6_full_switches_target: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_mode && ev_accept && (wr_fill == CNT_W'(DEPTH - 1))) |=> (wr_sel != $past(wr_sel)));

  a_r3_hidden_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ok |-> (cur_count == '0));

  always @(posedge clk) begin
    if (rst_n) begin
      a_r12_count_cap: assert (cur_count <= CNT_W'(DEPTH));
    end
  end

endmodule

bind blkrx_mgr blkrx_chk #(.DEPTH(BUF_BYTES), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .eod           (eod),
  .rx_err        (rx_err),
  .blk_mode      (blk_mode),
  .blk_clr       (blk_clr),
  .ovf           (ovf),
  .rx_ok         (rx_ok),
  .cur_count     (cur_count),
  .rd_sel        (rd_sel),
  .wr_sel        (wr_sel),
  .wr_fill       (wr_fill),
  .ev_accept     (ev_accept),
  .ev_overflow   (ev_overflow),
  .ev_release_ok (ev_release_ok)
);

// File: tb/sim_blkrx_mgr.sv
module sim_blkrx_mgr;

  localparam int DW  = 8;
  localparam int CAP = 8;
  localparam int CW  = $clog2(CAP + 1);
  localparam int IW  = $clog2(CAP);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          byte_vld = 1'b0;
  logic [DW-1:0] byte_data = '0;
  logic          eod = 1'b0;
  logic          crc_ok = 1'b0;
  logic          rx_err = 1'b0;
  logic          blk_set = 1'b0;
  logic          int_en = 1'b1;
  logic          buf_release = 1'b0;
  logic [IW-1:0] rd_idx = '0;
  logic          blk_mode, blk_clr, rx_ok, irq, ovf;
  logic [CW-1:0] cur_count;
  logic [DW-1:0] rd_data;

  always #2 clk = ~clk;

  blkrx_mgr #(.DATA_W(DW), .BUF_BYTES(CAP)) u0 (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .eod(eod), .crc_ok(crc_ok), .rx_err(rx_err), .blk_set(blk_set),
    .int_en(int_en), .buf_release(buf_release), .rd_idx(rd_idx),
    .blk_mode(blk_mode), .blk_clr(blk_clr), .rx_ok(rx_ok), .irq(irq),
    .ovf(ovf), .cur_count(cur_count), .rd_data(rd_data)
  );

  typedef struct {
    string tag;
    int    cnt;
    int    ok;
    int    irq;
    int    blk;
    int    ovf;
    int    data;
  } exp_t;

  exp_t exp_q[$];
  exp_t e;
  int   n_chk = 0;
  int   n_err = 0;
  int   clr_seen = 0;
  bit   done = 1'b0;

  task automatic chk(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Monitor: compares queued expectations against the outputs between edges.
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk({e.tag, " count"},    int'(cur_count), e.cnt);
      chk({e.tag, " success"},  int'(rx_ok),     e.ok);
      chk({e.tag, " irq"},      int'(irq),       e.irq);
      chk({e.tag, " block"},    int'(blk_mode),  e.blk);
      chk({e.tag, " overflow"}, int'(ovf),       e.ovf);
      if (e.data >= 0) chk({e.tag, " data"}, int'(rd_data), e.data);
    end
  end

  always @(negedge clk) if (rst_n && blk_clr) clr_seen++;

  // Driver tasks: each drives a strobe for one cycle, released just after the edge.
  task automatic send_byte(input int d);
    byte_vld = 1'b1; byte_data = DW'(d);
    @(posedge clk); #1;
    byte_vld = 1'b0;
  endtask

  task automatic send_bytes(input int base, input int n);
    for (int k = 0; k < n; k++) send_byte(base + k);
  endtask

  task automatic send_eod(input bit good);
    eod = 1'b1; crc_ok = good;
    @(posedge clk); #1;
    eod = 1'b0; crc_ok = 1'b0;
  endtask

  task automatic send_err();
    rx_err = 1'b1;
    @(posedge clk); #1;
    rx_err = 1'b0;
  endtask

  task automatic arm_block();
    blk_set = 1'b1;
    @(posedge clk); #1;
    blk_set = 1'b0;
  endtask

  task automatic do_release();
    buf_release = 1'b1;
    @(posedge clk); #1;
    buf_release = 1'b0;
  endtask

  // Pushes one expectation; interrupt follows R4 from the bench's own enable.
  task automatic push_exp(input string tag, input int cnt, input int ok,
                          input int blk, input int ov, input int idx, input int data);
    exp_t x;
    rd_idx = IW'(idx);
    x.tag = tag; x.cnt = cnt; x.ok = ok; x.irq = ok & int'(int_en);
    x.blk = blk; x.ovf = ov; x.data = data;
    exp_q.push_back(x);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    push_exp("R1 reset state", 0, 0, 0, 0, 0, -1);
    chk("R1 no clear pulse", clr_seen, 0);

    // Normal message
    send_bytes(8'h10, 2);
    push_exp("R3 filling buffer hidden", 0, 0, 0, 0, 0, -1);
    send_byte(8'h12);
    send_eod(1'b1);
    push_exp("R2 message visible", 3, 1, 0, 0, 1, 8'h11);
    push_exp("R2 last byte", 3, 1, 0, 0, 2, 8'h12);
    int_en = 1'b0;
    push_exp("R4 interrupt masked", 3, 1, 0, 0, 0, 8'h10);
    int_en = 1'b1;
    push_exp("R4 interrupt enabled", 3, 1, 0, 0, 0, 8'h10);

    // Release, stray release
    do_release();
    push_exp("R11 release empties view", 0, 0, 0, 0, 0, -1);
    do_release();
    send_byte(8'h55);
    send_eod(1'b1);
    push_exp("R11 stray release ignored", 1, 1, 0, 0, 0, 8'h55);
    do_release();

    // Error discards
    send_bytes(8'h20, 2);
    send_eod(1'b0);
    push_exp("R5 failed check dropped", 0, 0, 0, 0, 0, -1);
    send_byte(8'h30);
    send_err();
    send_bytes(8'h31, 2);
    send_eod(1'b1);
    push_exp("R5 error dropped partial", 2, 1, 0, 0, 0, 8'h31);
    do_release();

    // Block mode, good end
    arm_block();
    push_exp("R6 block armed", 0, 0, 1, 0, 0, -1);
    send_bytes(8'h40, 7);
    push_exp("R3 block partial hidden", 0, 0, 1, 0, 0, -1);
    send_byte(8'h47);
    push_exp("R6 full buffer completes", 8, 1, 1, 0, 7, 8'h47);
    send_bytes(8'h48, 3);
    push_exp("R7 count not cumulative", 8, 1, 1, 0, 0, 8'h40);
    do_release();
    push_exp("R11 partial not presented", 0, 0, 1, 0, 0, -1);
    send_eod(1'b1);
    push_exp("R8 end completes tail", 3, 1, 0, 0, 0, 8'h48);
    chk("R8 one clear pulse", clr_seen, 1);
    do_release();

    // Block mode, double-full overflow
    arm_block();
    send_bytes(8'h60, 16);
    push_exp("R6 both buffers filled", 8, 1, 1, 0, 0, 8'h60);
    send_byte(8'hEE);
    push_exp("R10 overflow ends block", 8, 1, 0, 1, 0, 8'h60);
    chk("R10 clear pulse on overflow", clr_seen, 2);
    push_exp("R10 overflow flag holds", 8, 1, 0, 1, 0, 8'h60);
    do_release();
    push_exp("R10 release clears overflow", 8, 1, 0, 0, 7, 8'h6F);
    do_release();
    push_exp("R11 all released", 0, 0, 0, 0, 0, -1);

    // Block mode, error
    arm_block();
    send_bytes(8'h70, 5);
    send_err();
    push_exp("R9 error ends block", 0, 0, 0, 0, 0, -1);
    chk("R9 clear pulse on error", clr_seen, 3);
    send_bytes(8'h7A, 2);
    send_eod(1'b1);
    push_exp("R5 block partial discarded", 2, 1, 0, 0, 0, 8'h7A);
    do_release();

    // Block mode, failed check at end
    arm_block();
    send_bytes(8'h80, 10);
    send_eod(1'b0);
    push_exp("R8 failed end keeps full buffer", 8, 1, 0, 0, 0, 8'h80);
    chk("R8 clear pulse on failed end", clr_seen, 4);
    do_release();
    push_exp("R8 failed tail dropped", 0, 0, 0, 0, 0, -1);

    // Normal mode excess
    send_bytes(8'h90, 10);
    send_eod(1'b1);
    push_exp("R12 excess bytes dropped", 8, 1, 0, 0, 7, 8'h97);
    do_release();

    // Normal mode overflow
    send_byte(8'hA1);
    send_eod(1'b1);
    send_bytes(8'hB1, 2);
    send_eod(1'b1);
    send_byte(8'hC1);
    push_exp("R10 normal overflow", 1, 1, 0, 1, 0, 8'hA1);
    chk("R10 no pulse outside block", clr_seen, 4);
    do_release();
    push_exp("R10 second message intact", 2, 1, 0, 0, 1, 8'hB2);
    do_release();
    push_exp("R11 view empty at end", 0, 0, 0, 0, 0, -1);

    @(posedge clk); #1;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule